// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits between five peripheral interrupt request lines and a small 8-bit processor core. It owns three pieces of state: the global interrupt enable, the halt flag and an 8-bit per-source enable mask. Each time the core reaches an instruction boundary it raises `step`. In that same cycle the controller chooses one of three outcomes: start an interrupt dispatch, wake from halt, or let the core fetch normally. If the core stays halted, the step is charged as an idle step instead.

A dispatch takes three further cycles. The controller stores the 16-bit return address on the stack one byte per cycle through a byte-wide write port, high byte first. It then hands the core a new program counter and a new stack pointer. In that last cycle it also pulses the acknowledge line of the one source it served and reports the cycle cost. `busy` is high for the whole sequence so the core holds off fetching. A halted core with the global enable off is woken by any pending, enabled request, and no dispatch takes place.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset the global enable, the halt flag and the enable mask are all clear, so `ime`, `halted`, `busy`, `mem_wr_en` and `irq_ack` are all 0, and a request on any line with the global enable then set still produces only `fetch_go`.
- R2: Source i (line `irq_req[i]`, enabled by mask bit i, where bit 0 is vertical blank, 1 display status, 2 timer, 3 serial, 4 keypad) has priority over every source with a higher index. Only the lowest-indexed request that is both pending and enabled is served on a step.
- R3: The new program counter for source i is 0x0040 + 8*i.
- R4: A dispatch writes the high program-counter byte to SP-1 in the first cycle after the step and the low byte to SP-2 in the second, with 16-bit wraparound. The new stack pointer is SP-2.
- R5: In the third cycle after the step, `pc_load` and `sp_load` pulse for one cycle, `irq_ack` pulses for one cycle with only the served bit set, and `ime` reads 0 from the first cycle after the step on.
- R6: A dispatch reports `cost_valid` with `cost` = 24 in the same cycle as `pc_load`.
- R7: A step with the core halted, `ime` clear, and a request that is pending and enabled clears `halted`, raises `fetch_go` in that cycle and starts no dispatch.
- R8: A step with the core halted and no request that is pending and enabled raises `cost_valid` with `cost` = 4 and no `fetch_go`, and `halted` stays set.
- R9: A dispatch taken while halted clears `halted`.
- R10: There is no dispatch when `ime` is clear or when the enable mask hides every pending line. The step then gives `fetch_go` (if not halted).
- R11: While `busy` is high, `step` is ignored and `fetch_go` stays low. The push sequence runs to its end with the source and addresses latched at the step.
- R12: `ime_clr` wins over `ime_set` in the same cycle, and a dispatch clears `ime` even when `ime_set` arrives in its step cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 5 | Pending request level per source |
| irq_ack | output | 5 | One-cycle acknowledge to the served source |
| mask_wr_en | input | 1 | Write strobe for the enable mask |
| mask_wr_data | input | 8 | New enable mask value |
| ime_set | input | 1 | Strobe that sets the global enable |
| ime_clr | input | 1 | Strobe that clears the global enable |
| halt_req | input | 1 | Strobe that enters the halt state |
| step | input | 1 | Core is at an instruction boundary |
| pc_in | input | 16 | Core program counter at the step |
| sp_in | input | 16 | Core stack pointer at the step |
| fetch_go | output | 1 | Core may fetch the next instruction |
| busy | output | 1 | Push sequence in progress |
| mem_wr_en | output | 1 | Stack byte write strobe |
| mem_wr_addr | output | 16 | Stack byte address |
| mem_wr_data | output | 8 | Stack byte value |
| pc_load | output | 1 | Load `pc_val` into the core program counter |
| pc_val | output | 16 | Interrupt vector |
| sp_load | output | 1 | Load `sp_val` into the core stack pointer |
| sp_val | output | 16 | Stack pointer after the push |
| cost_valid | output | 1 | `cost` is valid this cycle |
| cost | output | 5 | Cycles charged: 24 for a dispatch, 4 for a halted step |
| ime | output | 1 | Global interrupt enable |
| halted | output | 1 | Halt state |

## Verification
Two sets of events can land in the same cycle. In the first, a dispatch decision meets an `ime_set` strobe. In the second, a halted step meets a wake. The bench drives `ime_set` in exactly the cycle `step` is taken, and then judges that `ime` reads 0 after the vector load. It also starts a dispatch from the halted state and expects the halt flag to drop together with the start of the push, not a wake-only fetch. A further case raises `step` again, with a higher-priority request, in the middle of a push. The written bytes, the vector and the acknowledge must still belong to the source latched at the first step.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HI   = 2'd1,
    PS_LO   = 2'd2,
    PS_VEC  = 2'd3
  } push_st_e;
endpackage

// File: rtl/irqd_prio_pick.sv
// Fixed-priority pick: the lowest set index wins.
module irqd_prio_pick #(
  parameter int N     = 5,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic             hit,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx
);
  logic [N-1:0] below_any;

  assign below_any[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_chain
      assign below_any[gi] = below_any[gi-1] | cand[gi-1];
    end
  endgenerate

  assign grant = cand & ~below_any;
  assign hit   = |cand;

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) grant_idx = grant_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqd_state_regs.sv
// Global enable, halt flag and enable mask.
module irqd_state_regs #(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ime_set,
  input  logic              ime_clr,
  input  logic              halt_req,
  input  logic              mask_wr_en,
  input  logic [MASK_W-1:0] mask_wr_data,
  input  logic              disp_fire,
  input  logic              wake_fire,
  output logic              ime_q,
  output logic              halted_q,
  output logic [MASK_W-1:0] mask_q
);
  logic              ime_d;
  logic              halted_d;
  logic [MASK_W-1:0] mask_d;

  always_comb begin
    ime_d = ime_q;
    if (disp_fire)    ime_d = 1'b0;
    else if (ime_clr) ime_d = 1'b0;
    else if (ime_set) ime_d = 1'b1;

    halted_d = halted_q;
    if (disp_fire || wake_fire) halted_d = 1'b0;
    else if (halt_req)          halted_d = 1'b1;

    mask_d = mask_q;
    if (mask_wr_en) mask_d = mask_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q    <= 1'b0;
      halted_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      ime_q    <= ime_d;
      halted_q <= halted_d;
      mask_q   <= mask_d;
    end
  end

  a_r12_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ime_clr |=> !ime_q);
  a_r12_disp_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && ime_set) |=> !ime_q);
endmodule

// File: rtl/irqd_push_seq.sv
// Return-address push, vector load and acknowledge sequencer.
module irqd_push_seq
  import irqd_pkg::*;
#(
  parameter int                N          = 5,
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 2 * DATA_W,
  parameter int                IDX_W      = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
  parameter int                VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [N-1:0]      grant,
  input  logic [IDX_W-1:0]  grant_idx,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_val,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_val,
  output logic [N-1:0]      ack,
  output logic              done
);
  push_st_e          st_q, st_d;
  logic [ADDR_W-1:0] pc_q, sp_q;
  logic [N-1:0]      grant_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cap_en;
  logic [ADDR_W-1:0] sp_m1, sp_m2, vec;

  assign cap_en = start && (st_q == PS_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_IDLE: if (start) st_d = PS_HI;
      PS_HI:   st_d = PS_LO;
      PS_LO:   st_d = PS_VEC;
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      pc_q    <= '0;
      sp_q    <= '0;
      grant_q <= '0;
      idx_q   <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        pc_q    <= pc_in;
        sp_q    <= sp_in;
        grant_q <= grant;
        idx_q   <= grant_idx;
      end
    end
  end

  assign sp_m1 = sp_q - ADDR_W'(1);
  assign sp_m2 = sp_q - ADDR_W'(2);
  assign vec   = VEC_BASE + ADDR_W'(idx_q) * ADDR_W'(VEC_STRIDE);

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    case (st_q)
      PS_HI: begin
        wr_en   = 1'b1;
        wr_addr = sp_m1;
        wr_data = pc_q[ADDR_W-1:DATA_W];
      end
      PS_LO: begin
        wr_en   = 1'b1;
        wr_addr = sp_m2;
        wr_data = pc_q[DATA_W-1:0];
      end
      default: ;
    endcase
  end

  assign busy    = (st_q != PS_IDLE);
  assign done    = (st_q == PS_VEC);
  assign pc_load = done;
  assign pc_val  = done ? vec : '0;
  assign sp_load = done;
  assign sp_val  = done ? sp_m2 : '0;
  assign ack     = done ? grant_q : '0;

  a_r4_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HI) |=> (wr_en && wr_addr == $past(wr_addr) - ADDR_W'(1)));
  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |=> !(|ack));
  a_r11_push_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_LO) |=> done);
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
  parameter int NUM_SRC       = 5,
  parameter int DATA_W        = 8,
  parameter int MASK_W        = 8,
  parameter int VEC_BASE      = 'h40,
  parameter int VEC_STRIDE    = 8,
  parameter int DISPATCH_COST = 24,
  parameter int HALT_COST     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    irq_req,
  output logic [NUM_SRC-1:0]    irq_ack,
  input  logic                  mask_wr_en,
  input  logic [MASK_W-1:0]     mask_wr_data,
  input  logic                  ime_set,
  input  logic                  ime_clr,
  input  logic                  halt_req,
  input  logic                  step,
  input  logic [2*DATA_W-1:0]   pc_in,
  input  logic [2*DATA_W-1:0]   sp_in,
  output logic                  fetch_go,
  output logic                  busy,
  output logic                  mem_wr_en,
  output logic [2*DATA_W-1:0]   mem_wr_addr,
  output logic [DATA_W-1:0]     mem_wr_data,
  output logic                  pc_load,
  output logic [2*DATA_W-1:0]   pc_val,
  output logic                  sp_load,
  output logic [2*DATA_W-1:0]   sp_val,
  output logic                  cost_valid,
  output logic [$clog2(DISPATCH_COST+1)-1:0] cost,
  output logic                  ime,
  output logic                  halted
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int COST_W = $clog2(DISPATCH_COST + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [MASK_W-1:0]  mask_q;
  logic [NUM_SRC-1:0] pend_en, grant;
  logic [IDX_W-1:0]   grant_idx;
  logic               any_pend, can_decide, disp_fire, wake_fire, halt_idle, seq_done;

  assign pend_en    = irq_req & mask_q[NUM_SRC-1:0];
  assign can_decide = step && !busy;
  assign disp_fire  = can_decide && ime && (|mask_q) && any_pend;
  assign wake_fire  = can_decide && halted && !ime && any_pend;
  assign halt_idle  = can_decide && halted && !any_pend;
  assign fetch_go   = can_decide && !disp_fire && (!halted || wake_fire);

  irqd_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .cand      (pend_en),
    .hit       (any_pend),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  irqd_state_regs #(.MASK_W(MASK_W)) u_state (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .ime_set      (ime_set),
    .ime_clr      (ime_clr),
    .halt_req     (halt_req),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .disp_fire    (disp_fire),
    .wake_fire    (wake_fire),
    .ime_q        (ime),
    .halted_q     (halted),
    .mask_q       (mask_q)
  );

  irqd_push_seq #(
    .N          (NUM_SRC),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .VEC_BASE   (ADDR_W'(VEC_BASE)),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (disp_fire),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .grant     (grant),
    .grant_idx (grant_idx),
    .busy      (busy),
    .wr_en     (mem_wr_en),
    .wr_addr   (mem_wr_addr),
    .wr_data   (mem_wr_data),
    .pc_load   (pc_load),
    .pc_val    (pc_val),
    .sp_load   (sp_load),
    .sp_val    (sp_val),
    .ack       (irq_ack),
    .done      (seq_done)
  );

  assign cost_valid = seq_done || halt_idle;
  assign cost       = seq_done  ? COST_W'(DISPATCH_COST) :
                      halt_idle ? COST_W'(HALT_COST) : '0;

  a_r2_one_ack: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(irq_ack));
  a_r5_ime_drops: assert property (@(posedge clk) disable iff (!rst_core_n)
    disp_fire |=> !ime);
  a_r9_halt_drops: assert property (@(posedge clk) disable iff (!rst_core_n)
    disp_fire |=> (!halted && busy));
  a_r7_wake_no_push: assert property (@(posedge clk) disable iff (!rst_core_n)
    wake_fire |=> (!halted && !busy));
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    halt_idle |=> halted);
  a_r6_cost_with_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    pc_load |-> (cost_valid && cost == COST_W'(DISPATCH_COST)));
  a_r11_push_not_fetch: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_wr_en |-> !fetch_go);
endmodule

// File: tb/irq_dispatch_ctrl_tb_top.sv
module irq_dispatch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  irq_req, irq_ack;
  logic        mask_wr_en;
  logic [7:0]  mask_wr_data;
  logic        ime_set, ime_clr, halt_req, step;
  logic [15:0] pc_in, sp_in;
  logic        fetch_go, busy, mem_wr_en, pc_load, sp_load, cost_valid, ime, halted;
  logic [15:0] mem_wr_addr, pc_val, sp_val;
  logic [7:0]  mem_wr_data;
  logic [4:0]  cost;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_dispatch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .ime_set(ime_set), .ime_clr(ime_clr), .halt_req(halt_req), .step(step),
    .pc_in(pc_in), .sp_in(sp_in), .fetch_go(fetch_go), .busy(busy),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .pc_load(pc_load), .pc_val(pc_val), .sp_load(sp_load), .sp_val(sp_val),
    .cost_valid(cost_valid), .cost(cost), .ime(ime), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_ime_set();
    ime_set = 1'b1; next_cyc(); ime_set = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_wr_en = 1'b1; mask_wr_data = m; next_cyc(); mask_wr_en = 1'b0;
  endtask

  task automatic enter_halt();
    halt_req = 1'b1; next_cyc(); halt_req = 1'b0;
  endtask

  // Step with a dispatch expected; checks R3..R6 over the sequence.
  task automatic run_dispatch(input logic [15:0] pc, input logic [15:0] sp,
                              input logic [15:0] exp_vec, input logic [4:0] exp_ack,
                              input bit set_same_cycle);
    pc_in = pc; sp_in = sp; step = 1'b1; ime_set = set_same_cycle;
    #1;
    chk(!fetch_go, "R10 no fetch on dispatch step", fetch_go, 0);
    next_cyc(); step = 1'b0; ime_set = 1'b0;
    chk(mem_wr_en && mem_wr_addr == sp - 16'd1 && mem_wr_data == pc[15:8],
        "R4 high byte", {mem_wr_addr, mem_wr_data}, {sp - 16'd1, pc[15:8]});
    chk(busy && !ime, "R5 busy and ime clear", {busy, ime}, 2'b10);
    next_cyc();
    chk(mem_wr_en && mem_wr_addr == sp - 16'd2 && mem_wr_data == pc[7:0],
        "R4 low byte", {mem_wr_addr, mem_wr_data}, {sp - 16'd2, pc[7:0]});
    next_cyc();
    chk(pc_load && pc_val == exp_vec, "R3 vector", pc_val, exp_vec);
    chk(irq_ack == exp_ack, "R2 ack", irq_ack, exp_ack);
    chk(sp_load && sp_val == sp - 16'd2, "R4 new sp", sp_val, sp - 16'd2);
    chk(cost_valid && cost == 5'd24, "R6 cost", cost, 24);
    next_cyc();
    chk(!busy && irq_ack == 0 && !pc_load, "R5 single-cycle ack", {busy, irq_ack}, 0);
  endtask

  task automatic t_reset();
    chk(!ime && !halted && !busy && !mem_wr_en && irq_ack == 0, "R1 reset state",
        {ime, halted, busy, mem_wr_en, irq_ack}, 0);
    pulse_ime_set();
    irq_req = 5'h1F; step = 1'b1; #1;
    chk(fetch_go, "R1 mask clear blocks dispatch", fetch_go, 1);
    next_cyc(); step = 1'b0;
    chk(!busy, "R1 no push after reset", busy, 0);
    irq_req = 0;
  endtask

  task automatic t_single();
    set_mask(8'h1F);
    irq_req = 5'h04;
    run_dispatch(16'h1234, 16'hFFFE, 16'h0050, 5'h04, 1'b0);
    irq_req = 0;
  endtask

  task automatic t_priority();
    pulse_ime_set();
    irq_req = 5'h1E;
    run_dispatch(16'h2000, 16'hC100, 16'h0048, 5'h02, 1'b0);
    set_mask(8'h18);
    pulse_ime_set();
    irq_req = 5'h1F;
    run_dispatch(16'h2100, 16'hC100, 16'h0058, 5'h08, 1'b0);
    irq_req = 0;
  endtask

  task automatic t_wrap();
    set_mask(8'h1F);
    pulse_ime_set();
    irq_req = 5'h10;
    run_dispatch(16'hABCD, 16'h0001, 16'h0060, 5'h10, 1'b0);
    irq_req = 0;
  endtask

  task automatic t_ime_off();
    irq_req = 5'h01; step = 1'b1; #1;
    chk(fetch_go && !ime, "R10 ime off gives fetch", fetch_go, 1);
    next_cyc(); step = 1'b0;
    chk(!busy && !mem_wr_en, "R10 no push with ime off", busy, 0);
    irq_req = 0;
  endtask

  task automatic t_halt_wake();
    enter_halt();
    chk(halted, "R8 halt entered", halted, 1);
    step = 1'b1; #1;
    chk(cost_valid && cost == 5'd4 && !fetch_go, "R8 idle halted step",
        {cost_valid, cost, fetch_go}, {1'b1, 5'd4, 1'b0});
    next_cyc(); step = 1'b0;
    chk(halted, "R8 stays halted", halted, 1);
    irq_req = 5'h08; step = 1'b1; #1;
    chk(fetch_go && !cost_valid, "R7 wake fetch", fetch_go, 1);
    next_cyc(); step = 1'b0;
    chk(!halted && !busy && !mem_wr_en, "R7 woke without dispatch", {halted, busy}, 0);
    irq_req = 0;
  endtask

  task automatic t_halt_dispatch();
    pulse_ime_set();
    enter_halt();
    irq_req = 5'h01;
    pc_in = 16'h0300; sp_in = 16'hD000; step = 1'b1; #1;
    next_cyc(); step = 1'b0;
    chk(!halted && busy, "R9 dispatch clears halt", {halted, busy}, 2'b01);
    next_cyc(); next_cyc();
    chk(pc_val == 16'h0040 && irq_ack == 5'h01, "R9 vector", pc_val, 16'h0040);
    next_cyc();
    irq_req = 0;
  endtask

  task automatic t_same_cycle();
    pulse_ime_set();
    irq_req = 5'h08;
    run_dispatch(16'h4567, 16'h8000, 16'h0058, 5'h08, 1'b1);
    chk(!ime, "R12 dispatch beats ime_set", ime, 0);
    ime_set = 1'b1; ime_clr = 1'b1; next_cyc(); ime_set = 1'b0; ime_clr = 1'b0;
    chk(!ime, "R12 clear beats set", ime, 0);
    irq_req = 0;
  endtask

  task automatic t_busy_ignore();
    pulse_ime_set();
    irq_req = 5'h10;
    pc_in = 16'h5A5A; sp_in = 16'h9000; step = 1'b1; #1;
    next_cyc();
    irq_req = 5'h11; pc_in = 16'h1111; sp_in = 16'h2222; #1;
    chk(!fetch_go, "R11 no fetch while busy", fetch_go, 0);
    next_cyc(); step = 1'b0;
    chk(mem_wr_addr == 16'h8FFE && mem_wr_data == 8'h5A, "R11 latched push",
        {mem_wr_addr, mem_wr_data}, {16'h8FFE, 8'h5A});
    next_cyc();
    chk(pc_val == 16'h0060 && irq_ack == 5'h10, "R11 latched source", pc_val, 16'h0060);
    next_cyc();
    chk(!busy, "R11 sequence ends", busy, 0);
    irq_req = 0;
  endtask

  initial begin
    rst_n = 1'b0; irq_req = 0; mask_wr_en = 0; mask_wr_data = 0;
    ime_set = 0; ime_clr = 0; halt_req = 0; step = 0; pc_in = 0; sp_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) next_cyc();
    t_reset();
    t_single();
    t_priority();
    t_wrap();
    t_ime_off();
    t_halt_wake();
    t_halt_dispatch();
    t_same_cycle();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule